// File: doc/BRIEF.md
# Framed SPI Frame-Sync Controller

This block adds a framed mode to a serial shift path. The select line does not act as a chip select held for the whole transfer. It carries a frame synchronization pulse one bit period long, and the serial clock runs without stopping. Two roles are chosen independently of each other:

- **Clock role.** The block either divides its system clock to make the serial clock, or it follows a serial clock from outside.
- **Frame role.** As frame master the block drives the sync pulse itself. As frame slave it watches for an incoming pulse and aligns its next word to it.

Static configuration inputs select the remaining options:

- the active level of the sync pulse;
- which serial clock edge launches data and sync (the opposite edge samples);
- whether the pulse comes one bit ahead of the first data bit or together with it;
- whether the data output holds its last bit or drives zero between frames.

Words are `W` bits long and go out most significant bit first. `tx_word` is latched when a frame starts. Each complete received word appears on `rx_word` together with a one-cycle `rx_valid`.

The sequencer has three states:

- `ST_IDLE`: between frames.
- `ST_SYNC`: a sync bit is in progress and no data is on the line yet.
- `ST_SHIFT`: data bits are on the line, with a counter naming the bit currently driven.

The transitions are:

- **start_early.** `ST_IDLE`→`ST_SYNC`. A frame master in early mode takes it at a launch edge while enabled. A frame slave in early mode takes it at a sample edge that sees an active pulse.
- **start_coincident.** `ST_IDLE`→`ST_SHIFT`. A frame master in coincident mode takes it at a launch edge. A frame slave takes it at a sample edge that sees the pulse, and that sample is already the first data bit.
- **sync_done.** `ST_SYNC`→`ST_SHIFT`, taken at the next launch edge.
- **next_bit.** `ST_SHIFT`→`ST_SHIFT`, taken at a launch edge while the counter is above zero.
- **word_done.** `ST_SHIFT`→`ST_IDLE`, taken at the launch edge that follows bit 0.

Top module: `fsync_spi_ctrl`

## Requirements
- R1: While `rst_n` is low:
  - `sclk_out` is 0, `rx_valid` is 0, and `fsync_out` sits at its inactive level (the inverse of `fs_high`);
  - `ser_out` is 0, except for a coincident-mode frame slave, which shows `tx_word[W-1]`.
- R2: When `clk_master`=1, `sclk_out` toggles every `HALF` system clock cycles at all times, whether or not frames run. `sclk_oe` equals `clk_master`. When `clk_master`=0, the edges of `sclk_in` are used instead.
- R3: As frame master with `frm_early`=1, the sync pulse occupies the bit period just before the most significant data bit.
- R4: As frame master with `frm_early`=0, the sync pulse occupies the same bit period as the most significant data bit.
- R5: Sync polarity and width:
  - the sync pulse lasts exactly one bit period (2·`HALF` system cycles);
  - its active level is `fs_high`;
  - `fsync_oe` equals `frm_master`;
  - a frame slave never drives an active level.
- R6: Launch and sample edges:
  - with `launch_rise`=1, data and sync change on the rising serial clock edge and `ser_in` is sampled on the falling edge; `launch_rise`=0 swaps the two edges;
  - a word goes out most significant bit first;
  - after its W-th sample, `rx_word` holds the received word and `rx_valid` pulses for one cycle.
- R7: As frame slave in early mode, the block keeps `ser_out` idle until it samples an active pulse. It launches the first data bit on the next launch edge.
- R8: As frame slave in coincident mode:
  - the sample that sees the pulse is taken as the first data bit;
  - while idle, `ser_out` presents `tx_word[W-1]`.
- R9: Sync pulses that arrive while a word is in progress are ignored. The word and the frame after it are received unchanged.
- R10: Between frames, `ser_out` holds the last bit sent when `idle_zero`=0, and drives 0 when `idle_zero`=1.
- R11: With `clk_master`=0, all framing follows `sclk_in` edges in both frame roles.
- R12: With `en`=0, no frame starts:
  - a frame master drives no sync pulse;
  - a frame slave ignores incoming pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new frames to start |
| clk_master | input | 1 | 1: generate the serial clock; 0: follow `sclk_in` |
| frm_master | input | 1 | 1: drive the sync pulse; 0: detect it |
| frm_early | input | 1 | 1: sync one bit before data; 0: sync together with the first bit |
| fs_high | input | 1 | Active level of the sync pulse |
| launch_rise | input | 1 | 1: launch on the rising edge; 0: launch on the falling edge |
| idle_zero | input | 1 | 1: drive 0 between frames; 0: hold the last bit |
| tx_word | input | W | Word to send, latched at frame start |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| fsync_in | input | 1 | Incoming sync pulse |
| fsync_out | output | 1 | Outgoing sync pulse |
| fsync_oe | output | 1 | Sync output enable |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out |
| rx_word | output | W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |

## Verification
The bench drives all four pairings of clock role and frame role, each with a different word, polarity, launch edge and idle policy. This separates a sync pulse placed early from one placed coincident. It also exposes a swapped launch and sample edge, an inverted pulse level, and a held idle level versus a zero one. In the frame-slave runs, a bench-side frame master sends known words and injects a stray pulse in the middle of one word. A design that restarts on such a pulse shows up as a corrupted word, both for that frame and for the frame after it. A phase with `en` low shows whether any pulse or word escapes while frames are disabled.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_SHIFT
    } fsync_state_t;
endpackage

// File: rtl/fsync_clk.sv
module fsync_clk #(
    parameter int HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_master,
    input  logic launch_rise,
    input  logic sclk_in,
    output logic sclk_out,
    output logic launch_tick,
    output logic sample_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] div_q;
    logic          sck_q;
    logic          sck_prev;
    logic          sck_eff;
    logic          rise;
    logic          fall;

    // free-running divider: the clock never stops in framed mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= '0;
            sck_q    <= 1'b0;
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_eff;
            if (div_q == CW'(HALF - 1)) begin
                div_q <= '0;
                sck_q <= ~sck_q;
            end else begin
                div_q <= div_q + CW'(1);
            end
        end
    end

    always_comb begin
        sck_eff     = clk_master ? sck_q : sclk_in;
        rise        = sck_eff & ~sck_prev;
        fall        = ~sck_eff & sck_prev;
        launch_tick = launch_rise ? rise : fall;
        sample_tick = launch_rise ? fall : rise;
    end

    assign sclk_out = sck_q;

    // R2: after a toggle the generated clock holds for at least one cycle
    a_r2_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q != $past(sck_q)) |=> $stable(sck_q));
endmodule

// File: rtl/fsync_seq.sv
module fsync_seq
    import fsync_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         frm_master,
    input  logic         frm_early,
    input  logic         idle_zero,
    input  logic         fs_seen,
    input  logic         launch_tick,
    input  logic         sample_tick,
    input  logic [W-1:0] tx_word,
    output logic         ser_out,
    output logic         fs_act,
    output logic         cap,
    output logic         last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    fsync_state_t  state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_m1;
    logic [W-1:0]  word_q;
    logic          sdo_q;
    logic          mst_start;
    logic          slv_early;
    logic          slv_coin;
    logic          pulse_ok;

    always_comb begin
        pulse_ok  = sample_tick && (state_q == ST_IDLE) && !frm_master && en && fs_seen;
        mst_start = launch_tick && (state_q == ST_IDLE) && frm_master && en;
        slv_early = pulse_ok && frm_early;
        slv_coin  = pulse_ok && !frm_early;
        cnt_m1    = cnt_q - CW'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mst_start)      state_d = frm_early ? ST_SYNC : ST_SHIFT;
                else if (slv_early) state_d = ST_SYNC;
                else if (slv_coin)  state_d = ST_SHIFT;
            end
            ST_SYNC:  if (launch_tick) state_d = ST_SHIFT;
            ST_SHIFT: if (launch_tick && cnt_q == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_q <= '0;
            sdo_q  <= 1'b0;
            fs_act <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (mst_start) begin
                        word_q <= tx_word;
                        fs_act <= 1'b1;
                        if (!frm_early) begin
                            cnt_q <= CW'(W - 1);
                            sdo_q <= tx_word[W-1];
                        end
                    end else if (slv_early) begin
                        word_q <= tx_word;
                    end else if (slv_coin) begin
                        word_q <= tx_word;
                        cnt_q  <= CW'(W - 1);
                        sdo_q  <= tx_word[W-1];
                    end
                end
                ST_SYNC: if (launch_tick) begin
                    fs_act <= 1'b0;
                    cnt_q  <= CW'(W - 1);
                    sdo_q  <= word_q[W-1];
                end
                ST_SHIFT: if (launch_tick) begin
                    fs_act <= 1'b0;
                    if (cnt_q == '0) begin
                        if (idle_zero) sdo_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_m1;
                        sdo_q <= word_q[cnt_m1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ser_out = ((state_q == ST_IDLE) && !frm_master && !frm_early) ? tx_word[W-1] : sdo_q;
        cap     = sample_tick && ((state_q == ST_SHIFT) || slv_coin);
        last    = (state_q == ST_SHIFT) && (cnt_q == '0);
    end

    // R5: the sync pulse is cleared at the launch edge that ends its bit
    a_r5_fs_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_act && launch_tick) |=> !fs_act);
    // R5: only a frame master raises the pulse
    a_r5_fs_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        fs_act |-> frm_master);
    // R9: a word in progress is never abandoned
    a_r9_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cnt_q != '0) |=> (state_q == ST_SHIFT));
    // R10: the idle output level does not move while idle
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> $stable(sdo_q));
endmodule

// File: rtl/fsync_rx.sv
module fsync_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         last,
    input  logic         ser_in,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);
    logic [W-1:0] sr_q;
    logic [W-1:0] sr_nx;

    assign sr_nx = {sr_q[W-2:0], ser_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q     <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= cap && last;
            if (cap) sr_q <= sr_nx;
            if (cap && last) rx_word <= sr_nx;
        end
    end

    // R6: each word is announced by a single-cycle strobe
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/fsync_spi_ctrl.sv
module fsync_spi_ctrl #(
    parameter int W    = 8,
    parameter int HALF = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clk_master,
    input  logic         frm_master,
    input  logic         frm_early,
    input  logic         fs_high,
    input  logic         launch_rise,
    input  logic         idle_zero,
    input  logic [W-1:0] tx_word,
    input  logic         sclk_in,
    output logic         sclk_out,
    output logic         sclk_oe,
    input  logic         fsync_in,
    output logic         fsync_out,
    output logic         fsync_oe,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);
    logic launch_tick;
    logic sample_tick;
    logic fs_act;
    logic cap;
    logic last;
    logic fs_seen;

    assign fs_seen   = (fsync_in == fs_high);
    assign fsync_out = fs_high ? fs_act : ~fs_act;
    assign fsync_oe  = frm_master;
    assign sclk_oe   = clk_master;

    fsync_clk #(.HALF(HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .clk_master(clk_master),
        .launch_rise(launch_rise), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .launch_tick(launch_tick), .sample_tick(sample_tick)
    );

    fsync_seq #(.W(W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .frm_master(frm_master),
        .frm_early(frm_early), .idle_zero(idle_zero), .fs_seen(fs_seen),
        .launch_tick(launch_tick), .sample_tick(sample_tick), .tx_word(tx_word),
        .ser_out(ser_out), .fs_act(fs_act), .cap(cap), .last(last)
    );

    fsync_rx #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cap(cap), .last(last), .ser_in(ser_in),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    // R6: launch and sample never fall in the same cycle
    a_r6_tick_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_tick && sample_tick));
endmodule

// File: tb/fsync_spi_ctrl_tb.sv
`timescale 1ns/1ps
module fsync_spi_ctrl_tb;
    localparam int W    = 8;
    localparam int HALF = 3;

    logic clk = 0;
    always #4 clk = ~clk;

    logic rst_n = 0, en = 0, cm = 1, fm = 1, early = 1, high = 1, rise = 1, idlez = 0;
    logic [W-1:0] txw = '0;
    logic sck_in = 0, fs_in = 0, sdi_drv = 0, loop = 1;
    logic sclk_out, sclk_oe, fsync_out, fsync_oe, ser_out, rx_valid;
    logic [W-1:0] rx_word;
    logic sdi_w;
    assign sdi_w = loop ? ser_out : sdi_drv;

    fsync_spi_ctrl #(.W(W), .HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .clk_master(cm), .frm_master(fm),
        .frm_early(early), .fs_high(high), .launch_rise(rise), .idle_zero(idlez),
        .tx_word(txw), .sclk_in(sck_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .fsync_in(fs_in), .fsync_out(fsync_out), .fsync_oe(fsync_oe),
        .ser_in(sdi_w), .ser_out(ser_out), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit done = 0;

    // external serial clock, changed away from the system clock edge
    initial forever begin
        repeat (HALF) @(negedge clk);
        #1 sck_in = ~sck_in;
    end

    // behavioural reference model
    int m_div, m_ph;
    logic m_sck, m_prev, m_sdo, m_fs, m_rxv;
    logic [W-1:0] m_word, m_acc, m_rxw;
    always @(posedge clk) begin
        logic cur, lt, st, take;
        if (!rst_n) begin
            m_div = 0; m_sck = 0; m_prev = 0; m_ph = -1; m_sdo = 0; m_fs = 0;
            m_rxv = 0; m_rxw = '0; m_acc = '0; m_word = '0;
        end else begin
            cur = cm ? m_sck : sck_in;
            lt  = rise ? (cur & ~m_prev) : (~cur & m_prev);
            st  = rise ? (~cur & m_prev) : (cur & ~m_prev);
            m_prev = cur;
            if (m_div == HALF - 1) begin m_div = 0; m_sck = ~m_sck; end
            else m_div++;
            m_rxv = 0;
            take  = 0;
            if (st) begin
                if (m_ph == -1 && !fm && en && fs_in == high) begin
                    m_word = txw;
                    if (early) m_ph = -2;
                    else begin m_ph = W - 1; m_sdo = txw[W-1]; take = 1; end
                end else if (m_ph >= 0) take = 1;
            end
            if (take) begin
                m_acc = {m_acc[W-2:0], sdi_w};
                if (m_ph == 0) begin m_rxw = m_acc; m_rxv = 1; end
            end
            if (lt) begin
                if (m_ph == -1) begin
                    if (fm && en) begin
                        m_word = txw; m_fs = 1;
                        if (early) m_ph = -2;
                        else begin m_ph = W - 1; m_sdo = txw[W-1]; end
                    end
                end else if (m_ph == -2) begin
                    m_fs = 0; m_ph = W - 1; m_sdo = m_word[W-1];
                end else begin
                    m_fs = 0;
                    if (m_ph == 0) begin m_ph = -1; if (idlez) m_sdo = 0; end
                    else begin m_ph--; m_sdo = m_word[m_ph]; end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison plus word and pulse-width checks
    logic [W-1:0] exp_q[$];
    int fs_run = 0, rx_seen = 0, fs_seen_cnt = 0;
    initial forever begin
        logic e_sdo, e_fs;
        logic [W-1:0] e_rx;
        @(posedge clk); #2;
        e_sdo = (m_ph == -1 && !fm && !early) ? txw[W-1] : m_sdo;
        e_fs  = high ? m_fs : ~m_fs;
        chk({ser_out, fsync_out, sclk_out, rx_valid, sclk_oe, fsync_oe} ===
            {e_sdo, e_fs, m_sck, m_rxv, cm, fm}, tag,
            {ser_out, fsync_out, sclk_out, rx_valid, sclk_oe, fsync_oe},
            {e_sdo, e_fs, m_sck, m_rxv, cm, fm});
        if (rst_n && rx_valid === 1'b1) begin
            rx_seen++;
            if (loop) e_rx = txw;
            else if (exp_q.size() > 0) e_rx = exp_q.pop_front();
            else e_rx = ~rx_word;
            chk(rx_word === e_rx, {"R6 word ", tag}, rx_word, e_rx);
        end
        if (rst_n && fm && fsync_out === high) fs_run++;
        else if (fs_run > 0) begin
            fs_seen_cnt++;
            chk(fs_run == 2 * HALF, "R5 pulse width", fs_run, 2 * HALF);
            fs_run = 0;
        end
    end

    function automatic logic sck_view();
        return cm ? sclk_out : sck_in;
    endfunction

    task automatic wait_launch();
        logic p, v;
        p = sck_view();
        forever begin
            @(negedge clk);
            v = sck_view();
            if (rise ? (v && !p) : (!v && p)) break;
            p = v;
        end
    endtask

    // bench-side frame master for the frame-slave runs
    task automatic ext_frame(input logic [W-1:0] w, input int midbit);
        exp_q.push_back(w);
        wait_launch();
        fs_in = high;
        if (!early) sdi_drv = w[W-1];
        for (int k = (early ? W - 1 : W - 2); k >= 0; k--) begin
            wait_launch();
            fs_in   = (k == midbit) ? high : ~high;
            sdi_drv = w[k];
        end
        wait_launch();
        fs_in = ~high; sdi_drv = 0;
        wait_launch();
        wait_launch();
    endtask

    task automatic setup(input logic c_cm, c_fm, c_early, c_high, c_rise, c_idlez,
                         input logic [W-1:0] w, input logic c_loop, input string t);
        @(negedge clk);
        rst_n = 0;
        cm = c_cm; fm = c_fm; early = c_early; high = c_high; rise = c_rise;
        idlez = c_idlez; txw = w; loop = c_loop; en = 1;
        fs_in = ~c_high; sdi_drv = 0;
        exp_q.delete(); rx_seen = 0; fs_seen_cnt = 0; fs_run = 0;
        tag = "R1";
        repeat (3) @(negedge clk);
        chk(ser_out === ((!c_fm && !c_early) ? w[W-1] : 1'b0), "R1 ser_out", ser_out, 0);
        chk({fsync_out, sclk_out, rx_valid} === {~c_high, 2'b00}, "R1 outputs",
            {fsync_out, sclk_out, rx_valid}, {~c_high, 2'b00});
        tag = t;
        rst_n = 1;
    endtask

    initial begin
        // A: clock master, frame master, early sync, active high, rising launch, hold idle
        setup(1, 1, 1, 1, 1, 0, 8'hA5, 1, "R2 R3 R6 R10");
        repeat (450) @(negedge clk);
        chk(rx_seen >= 3, "R3 words", rx_seen, 3);
        chk(fs_seen_cnt >= 3, "R3 pulses", fs_seen_cnt, 3);

        // B: coincident sync, active low, falling launch, zero idle
        setup(1, 1, 0, 0, 0, 1, 8'h3C, 1, "R4 R5 R6 R10");
        repeat (450) @(negedge clk);
        chk(rx_seen >= 3, "R4 words", rx_seen, 3);

        // C: clock slave, frame slave, early sync, stray pulse mid word
        setup(0, 0, 1, 1, 1, 0, 8'h96, 0, "R7 R9 R11");
        repeat (20) @(negedge clk);
        ext_frame(8'h5A, -1);
        ext_frame(8'hC3, 4);
        ext_frame(8'h81, -1);
        repeat (20) @(negedge clk);
        chk(rx_seen == 3, "R7 R9 word count", rx_seen, 3);
        chk(exp_q.size() == 0, "R9 pending", exp_q.size(), 0);

        // D: clock master, frame slave, coincident sync, falling launch
        setup(1, 0, 0, 0, 0, 1, 8'hE7, 0, "R8 R9");
        repeat (20) @(negedge clk);
        chk(ser_out === 1'b1, "R8 idle shows msb", ser_out, 1);
        ext_frame(8'h6B, -1);
        ext_frame(8'h12, 3);
        ext_frame(8'hF0, -1);
        repeat (20) @(negedge clk);
        chk(rx_seen == 3, "R8 R9 word count", rx_seen, 3);

        // E: clock slave, frame master, disabled then enabled
        setup(0, 1, 1, 0, 0, 1, 8'h4D, 1, "R12");
        en = 0;
        repeat (200) @(negedge clk);
        chk(fs_seen_cnt == 0 && fs_run == 0, "R12 no pulse", fs_seen_cnt, 0);
        chk(rx_seen == 0, "R12 no word", rx_seen, 0);
        tag = "R11 R3 R10";
        en = 1;
        repeat (400) @(negedge clk);
        chk(rx_seen >= 3, "R11 words", rx_seen, 3);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule